// File: doc/BRIEF.md
# Priority group conversion scheduler

This block decides which channel group owns a shared analog converter. Up to eight groups are set up through static configuration inputs. Each group has a priority, a channel count and a run mode. A start request on a free unit runs the group at once. A start request on a busy unit is held in a pending list. If preemption is on and the new group has a strictly higher priority, it displaces the group that is running. The scheduler drives the active group number and the channel index that should be converted next. It advances that index each time the converter returns a per-channel done strobe.

A displaced group keeps its BUSY status and goes to the front of the pending list. When it runs again it always starts over at channel 0. A stop request ends the running group, and the next pending group takes the unit on the same clock edge. Every group has a two-bit status that tells whether it is idle, busy, finished, or finished with a multi-pass stream.

Top module: `grp_sched`

## Requirements
- R1: After reset every group status is IDLE (code 0), `active_vld_o` is low, and `done_o` and `err_o` are low.
- R2: Status codes are 0 IDLE, 1 BUSY, 2 COMPLETED, 3 STREAM_COMPLETED. A start request for a group whose status is not BUSY, made while the unit is free, shows that group on `active_id_o` with `ch_idx_o` = 0 and status BUSY on the next cycle.
- R3: While a group runs, each `ch_done_i` pulse on a channel other than its last moves `ch_idx_o` up by one. With no request and no strobe, the active group and channel index stay unchanged. The last channel of a group is index `cfg_len` (the group has cfg_len+1 channels).
- R4: A one-shot group (mode 0; mode 3 behaves the same) finishing its last channel pulses `done_o` for one cycle with `done_id_o` naming it. Its status becomes COMPLETED and the unit is released.
- R5: A continuous group (mode 1) finishing its last channel pulses `done_o`, wraps to channel 0 and stays BUSY until it is stopped or displaced.
- R6: A burst group (mode 2) runs cfg_pass+1 full passes. It pulses `done_o` after each pass, then ends with status STREAM_COMPLETED and releases the unit.
- R7: A start request accepted while the unit stays busy, and that does not preempt, is appended to the pending list. The group becomes BUSY and the running group and channel are unaffected.
- R8: A start request for a group whose status is BUSY (running or pending) is refused. `err_o` pulses on the next cycle and nothing else changes.
- R9: With `preempt_en_i` high, a start request with priority strictly above the running group's priority takes the unit from channel 0. The displaced group moves to the front of the pending list and later restarts from channel 0.
- R10: A start request of equal or lower priority never preempts. With `preempt_en_i` low nothing preempts, and pending groups are dispatched strictly in arrival order.
- R11: With `preempt_en_i` high, a freed unit takes the pending group with the highest priority (0 is lowest). Among equal priorities it takes the one nearest the front of the list.
- R12: A stop request naming the running group sets its status to IDLE and dispatches the next pending group on the same edge. A stop request naming any other group pulses `err_o` and changes nothing.
- R13: When the unit is freed in the same cycle that a new start request is accepted, the new request competes with the pending list. When preemption is on it wins only with strictly higher priority; otherwise it is appended behind the pending groups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preempt_en_i | input | 1 | Enables priority preemption and priority-based dispatch |
| cfg_prio_i | input | N_GRP*PRIO_W | Per-group priority, 0 lowest |
| cfg_len_i | input | N_GRP*LEN_W | Per-group index of the last channel |
| cfg_mode_i | input | N_GRP*2 | Per-group mode: 0 one-shot, 1 continuous, 2 burst |
| cfg_pass_i | input | N_GRP*PASS_W | Per-group burst pass count minus one |
| start_i | input | 1 | Start request strobe |
| start_id_i | input | GID_W | Group to start |
| stop_i | input | 1 | Stop request strobe |
| stop_id_i | input | GID_W | Group to stop |
| ch_done_i | input | 1 | Converter finished the current channel |
| active_vld_o | output | 1 | A group owns the unit |
| active_id_o | output | GID_W | Group that owns the unit |
| ch_idx_o | output | LEN_W | Channel index to convert next |
| status_o | output | N_GRP*2 | Per-group status codes |
| done_o | output | 1 | One-cycle pulse at the end of a pass |
| done_id_o | output | GID_W | Group whose pass ended |
| err_o | output | 1 | One-cycle pulse for a refused request |

## Verification
The case most likely to go wrong is a dispatch and a new start landing on the same edge. This happens when a stop request or a final channel strobe frees the unit in the cycle a start request arrives. The bench builds this case on purpose with equal and with higher priorities, and checks which group wins and where the loser lands in the pending list. It also pairs a pass end of a continuous group with a preempting start, and then expects both the completion pulse and the displacement. A behavioural model built on queues predicts every output each cycle, so any disagreement at those collisions is reported on the cycle where it happens.

// File: rtl/grp_sched_pkg.sv
package grp_sched_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSY   = 2'd1,
    ST_DONE   = 2'd2,
    ST_STREAM = 2'd3
  } grp_st_e;

  typedef enum logic [1:0] {
    MD_ONESHOT = 2'd0,
    MD_CONT    = 2'd1,
    MD_BURST   = 2'd2,
    MD_RSVD    = 2'd3
  } grp_md_e;

endpackage

// File: rtl/grp_sched_queue.sv
module grp_sched_queue #(
  parameter  int DEPTH = 8,
  parameter  int ID_W  = 3,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  rm_i,
  input  logic [IDX_W-1:0]      rm_idx_i,
  input  logic                  pf_i,
  input  logic [ID_W-1:0]       pf_id_i,
  input  logic                  pb_i,
  input  logic [ID_W-1:0]       pb_id_i,
  output logic [DEPTH*ID_W-1:0] ids_o,
  output logic [CNT_W-1:0]      cnt_o
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [ID_W-1:0]  q_q [DEPTH];
  logic [ID_W-1:0]  q_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // removal, then front insert, then back insert; rm and pf are exclusive
  always_comb begin
    q_d   = q_q;
    cnt_d = cnt_q;
    if (rm_i) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (i >= int'(rm_idx_i)) q_d[i] = q_d[i+1];
      end
      cnt_d = cnt_d - CNT_ONE;
    end
    if (pf_i) begin
      for (int i = DEPTH - 1; i > 0; i--) q_d[i] = q_d[i-1];
      q_d[0] = pf_id_i;
      cnt_d  = cnt_d + CNT_ONE;
    end
    if (pb_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (i == int'(cnt_d)) q_d[i] = pb_id_i;
      end
      cnt_d = cnt_d + CNT_ONE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) q_q[i] <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      cnt_q <= cnt_d;
    end
  end

  for (genvar s = 0; s < DEPTH; s++) begin : g_out
    assign ids_o[s*ID_W +: ID_W] = q_q[s];
  end
  assign cnt_o = cnt_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CNT_W'(DEPTH)) |-> !(pf_i || (pb_i && !rm_i))); // R7
  AST_FRONT_NO_REMOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pf_i && rm_i)); // R9
  AST_REMOVE_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rm_i |-> (CNT_W'(rm_idx_i) < cnt_q)); // R11

endmodule

// File: rtl/grp_sched_pick.sv
module grp_sched_pick #(
  parameter  int DEPTH  = 8,
  parameter  int PRIO_W = 3,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic [DEPTH*PRIO_W-1:0] prio_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic                    new_vld_i,
  input  logic [PRIO_W-1:0]       new_prio_i,
  input  logic                    by_prio_i,
  output logic                    any_o,
  output logic                    from_q_o,
  output logic [IDX_W-1:0]        idx_o
);

  logic              found;
  logic [PRIO_W-1:0] best;

  // strict compare keeps the earliest slot among equal priorities
  always_comb begin
    found = 1'b0;
    best  = '0;
    idx_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i < int'(cnt_i)) begin
        if (!found || (by_prio_i && (prio_i[i*PRIO_W +: PRIO_W] > best))) begin
          found = 1'b1;
          best  = prio_i[i*PRIO_W +: PRIO_W];
          idx_o = IDX_W'(i);
        end
      end
    end
    from_q_o = found && !(new_vld_i && by_prio_i && (new_prio_i > best));
    any_o    = found || new_vld_i;
  end

endmodule

// File: rtl/grp_sched.sv
module grp_sched
  import grp_sched_pkg::*;
#(
  parameter  int N_GRP   = 8,
  parameter  int PRIO_W  = 3,
  parameter  int LEN_W   = 4,
  parameter  int PASS_W  = 3,
  parameter  int Q_DEPTH = 8,
  localparam int GID_W   = $clog2(N_GRP),
  localparam int QI_W    = $clog2(Q_DEPTH),
  localparam int QC_W    = $clog2(Q_DEPTH + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    preempt_en_i,
  input  logic [N_GRP*PRIO_W-1:0] cfg_prio_i,
  input  logic [N_GRP*LEN_W-1:0]  cfg_len_i,
  input  logic [N_GRP*2-1:0]      cfg_mode_i,
  input  logic [N_GRP*PASS_W-1:0] cfg_pass_i,
  input  logic                    start_i,
  input  logic [GID_W-1:0]        start_id_i,
  input  logic                    stop_i,
  input  logic [GID_W-1:0]        stop_id_i,
  input  logic                    ch_done_i,
  output logic                    active_vld_o,
  output logic [GID_W-1:0]        active_id_o,
  output logic [LEN_W-1:0]        ch_idx_o,
  output logic [N_GRP*2-1:0]      status_o,
  output logic                    done_o,
  output logic [GID_W-1:0]        done_id_o,
  output logic                    err_o
);

  grp_st_e            st_q [N_GRP];
  logic               run_vld_q, run_vld_d;
  logic [GID_W-1:0]   run_id_q, run_id_d;
  logic [LEN_W-1:0]   ch_q, ch_d;
  logic [PASS_W-1:0]  pass_q, pass_d;
  logic               done_q, err_q;
  logic [GID_W-1:0]   done_id_q;

  logic [LEN_W-1:0]   run_len;
  grp_md_e            run_mode;
  logic [PASS_W-1:0]  run_pass;
  logic [PRIO_W-1:0]  run_prio, new_prio;

  logic pass_end, stop_hit, acc, last_pass, fin, run_free, preempt;

  logic [Q_DEPTH*GID_W-1:0]  q_ids;
  logic [QC_W-1:0]           q_cnt;
  logic [GID_W-1:0]          slot_id [Q_DEPTH];
  logic [Q_DEPTH*PRIO_W-1:0] slot_prio;
  logic                      pick_any, pick_from_q;
  logic [QI_W-1:0]           pick_idx;
  logic                      q_rm, q_pf, q_pb;

  // current-group configuration lookup
  assign run_len  = cfg_len_i[run_id_q*LEN_W +: LEN_W];
  assign run_mode = grp_md_e'(cfg_mode_i[run_id_q*2 +: 2]);
  assign run_pass = cfg_pass_i[run_id_q*PASS_W +: PASS_W];
  assign run_prio = cfg_prio_i[run_id_q*PRIO_W +: PRIO_W];
  assign new_prio = cfg_prio_i[start_id_i*PRIO_W +: PRIO_W];

  // request decode
  assign pass_end = run_vld_q && ch_done_i && (ch_q == run_len);
  assign stop_hit = stop_i && run_vld_q && (stop_id_i == run_id_q);
  assign acc      = start_i && (st_q[start_id_i] != ST_BUSY);

  always_comb begin
    unique case (run_mode)
      MD_CONT:  last_pass = 1'b0;
      MD_BURST: last_pass = (pass_q == run_pass);
      default:  last_pass = 1'b1;
    endcase
  end

  assign fin      = pass_end && !stop_hit && last_pass;
  assign run_free = !run_vld_q || stop_hit || fin;
  assign preempt  = !run_free && acc && preempt_en_i && (new_prio > run_prio);

  // pending list
  for (genvar s = 0; s < Q_DEPTH; s++) begin : g_slot
    assign slot_id[s] = q_ids[s*GID_W +: GID_W];
    assign slot_prio[s*PRIO_W +: PRIO_W] = cfg_prio_i[slot_id[s]*PRIO_W +: PRIO_W];
  end

  grp_sched_pick #(
    .DEPTH  (Q_DEPTH),
    .PRIO_W (PRIO_W)
  ) u_pick (
    .prio_i     (slot_prio),
    .cnt_i      (q_cnt),
    .new_vld_i  (acc && run_free),
    .new_prio_i (new_prio),
    .by_prio_i  (preempt_en_i),
    .any_o      (pick_any),
    .from_q_o   (pick_from_q),
    .idx_o      (pick_idx)
  );

  assign q_rm = run_free && pick_from_q;
  assign q_pf = preempt;
  assign q_pb = acc && (run_free ? pick_from_q : !preempt);

  grp_sched_queue #(
    .DEPTH (Q_DEPTH),
    .ID_W  (GID_W)
  ) u_queue (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rm_i     (q_rm),
    .rm_idx_i (pick_idx),
    .pf_i     (q_pf),
    .pf_id_i  (run_id_q),
    .pb_i     (q_pb),
    .pb_id_i  (start_id_i),
    .ids_o    (q_ids),
    .cnt_o    (q_cnt)
  );

  // running context
  always_comb begin
    run_vld_d = run_vld_q;
    run_id_d  = run_id_q;
    ch_d      = ch_q;
    pass_d    = pass_q;
    if (run_free) begin
      run_vld_d = pick_any;
      run_id_d  = pick_from_q ? slot_id[pick_idx] : start_id_i;
      ch_d      = '0;
      pass_d    = '0;
    end else if (preempt) begin
      run_id_d  = start_id_i;
      ch_d      = '0;
      pass_d    = '0;
    end else if (pass_end) begin
      ch_d      = '0;
      pass_d    = pass_q + PASS_W'(1);
    end else if (ch_done_i) begin
      ch_d      = ch_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_vld_q <= 1'b0;
      run_id_q  <= '0;
      ch_q      <= '0;
      pass_q    <= '0;
      done_q    <= 1'b0;
      done_id_q <= '0;
      err_q     <= 1'b0;
    end else begin
      run_vld_q <= run_vld_d;
      run_id_q  <= run_id_d;
      ch_q      <= ch_d;
      pass_q    <= pass_d;
      done_q    <= pass_end && !stop_hit;
      done_id_q <= run_id_q;
      err_q     <= (start_i && !acc) || (stop_i && !stop_hit);
    end
  end

  // per-group status
  for (genvar g = 0; g < N_GRP; g++) begin : g_st
    logic is_run;
    assign is_run = (run_id_q == GID_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q[g] <= ST_IDLE;
      end else if (stop_hit && is_run) begin
        st_q[g] <= ST_IDLE;
      end else if (fin && is_run) begin
        st_q[g] <= (run_mode == MD_BURST) ? ST_STREAM : ST_DONE;
      end else if (acc && (start_id_i == GID_W'(g))) begin
        st_q[g] <= ST_BUSY;
      end
    end

    assign status_o[g*2 +: 2] = st_q[g];
  end

  assign active_vld_o = run_vld_q;
  assign active_id_o  = run_id_q;
  assign ch_idx_o     = ch_q;
  assign done_o       = done_q;
  assign done_id_o    = done_id_q;
  assign err_o        = err_q;

  AST_RUN_IS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_vld_o |-> (st_q[active_id_o] == ST_BUSY)); // R2
  AST_CH_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_vld_o |-> (ch_idx_o <= run_len)); // R3
  AST_CH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_vld_o && !ch_done_i && !start_i && !stop_i)
      |=> (active_vld_o && $stable(ch_idx_o) && $stable(active_id_o))); // R3
  AST_DUP_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && (st_q[start_id_i] == ST_BUSY)) |=> err_o); // R8
  AST_DONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(ch_done_i)); // R4
  AST_ONESHOT_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_vld_o && ch_done_i && !start_i && !stop_i && (ch_idx_o == run_len)
      && (run_mode == MD_ONESHOT) && (q_cnt == '0)) |=> !active_vld_o); // R4

endmodule

// File: tb/grp_sched_tb.sv
`timescale 1ns/1ps
module grp_sched_tb;

  localparam int NG = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        preempt_en_i = 1'b1;
  logic [23:0] cfg_prio_i;
  logic [31:0] cfg_len_i;
  logic [15:0] cfg_mode_i;
  logic [23:0] cfg_pass_i;
  logic        start_i = 1'b0;
  logic [2:0]  start_id_i = '0;
  logic        stop_i = 1'b0;
  logic [2:0]  stop_id_i = '0;
  logic        ch_done_i = 1'b0;
  logic        active_vld_o;
  logic [2:0]  active_id_o;
  logic [3:0]  ch_idx_o;
  logic [15:0] status_o;
  logic        done_o;
  logic [2:0]  done_id_o;
  logic        err_o;

  always #2 clk_i = ~clk_i;

  grp_sched u_dut (
    .clk_i, .rst_ni, .preempt_en_i, .cfg_prio_i, .cfg_len_i, .cfg_mode_i,
    .cfg_pass_i, .start_i, .start_id_i, .stop_i, .stop_id_i, .ch_done_i,
    .active_vld_o, .active_id_o, .ch_idx_o, .status_o, .done_o, .done_id_o, .err_o
  );

  // group setup
  int prio [NG] = '{1, 1, 3, 5, 0, 7, 3, 2};
  int glen [NG] = '{2, 0, 1, 3, 0, 1, 2, 0};
  int gmod [NG] = '{0, 1, 2, 0, 0, 0, 1, 0};
  int gpas [NG] = '{0, 0, 1, 0, 0, 0, 0, 0};

  initial begin
    for (int g = 0; g < NG; g++) begin
      cfg_prio_i[g*3 +: 3] = 3'(prio[g]);
      cfg_len_i[g*4 +: 4]  = 4'(glen[g]);
      cfg_mode_i[g*2 +: 2] = 2'(gmod[g]);
      cfg_pass_i[g*3 +: 3] = 3'(gpas[g]);
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int st_of(input int g);
    return int'(status_o[g*2 +: 2]);
  endfunction

  // behavioural reference model
  int m_st [NG];
  int mq [$];
  int cand [$];
  bit m_vld, m_done, m_err;
  int m_id, m_ch, m_pass, m_done_id;
  bit pend, sh, ac, fn, fr;
  int k, s;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int g = 0; g < NG; g++) m_st[g] = 0;
      mq.delete();
      m_vld = 0; m_id = 0; m_ch = 0; m_pass = 0;
      m_done = 0; m_err = 0; m_done_id = 0;
    end else begin
      s    = int'(start_id_i);
      pend = m_vld && ch_done_i && (m_ch == glen[m_id]);
      sh   = stop_i && m_vld && (int'(stop_id_i) == m_id);
      ac   = start_i && (m_st[s] != 1);
      m_err = (start_i && !ac) || (stop_i && !sh);
      m_done = pend && !sh;
      m_done_id = m_id;
      fn = m_done && (gmod[m_id] != 1) && ((gmod[m_id] != 2) || (m_pass == gpas[m_id]));
      fr = !m_vld || sh || fn;
      if (sh) m_st[m_id] = 0;
      else if (fn) m_st[m_id] = (gmod[m_id] == 2) ? 3 : 2;
      else if (pend) begin m_ch = 0; m_pass++; end
      else if (m_vld && ch_done_i) m_ch++;
      if (ac) m_st[s] = 1;
      if (!fr) begin
        if (ac) begin
          if (preempt_en_i && (prio[s] > prio[m_id])) begin
            mq.push_front(m_id);
            m_id = s; m_ch = 0; m_pass = 0;
          end else begin
            mq.push_back(s);
          end
        end
      end else begin
        cand = mq;
        if (ac) cand.push_back(s);
        if (cand.size() == 0) begin
          m_vld = 0;
        end else begin
          k = 0;
          if (preempt_en_i)
            for (int i = 1; i < cand.size(); i++)
              if (prio[cand[i]] > prio[cand[k]]) k = i;
          m_id = cand[k];
          cand.delete(k);
          mq = cand;
          m_vld = 1; m_ch = 0; m_pass = 0;
        end
      end
    end
  end

  // per-clock comparison with the model
  always @(negedge clk_i) begin
    if (rst_ni && !ended) begin
      chk("R9", "active_vld", int'(active_vld_o), int'(m_vld));
      if (m_vld) begin
        chk("R9", "active_id", int'(active_id_o), m_id);
        chk("R3", "ch_idx", int'(ch_idx_o), m_ch);
      end
      for (int g = 0; g < NG; g++) chk("R2", "status", st_of(g), m_st[g]);
      chk("R5", "done", int'(done_o), int'(m_done));
      if (m_done) chk("R5", "done_id", int'(done_id_o), m_done_id);
      chk("R8", "err", int'(err_o), int'(m_err));
    end
  end

  task automatic cyc(input bit st, input int sid, input bit sp, input int tid, input bit dn);
    start_i = st; start_id_i = 3'(sid);
    stop_i = sp; stop_id_i = 3'(tid);
    ch_done_i = dn;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0; ch_done_i = 1'b0;
  endtask

  task automatic finish_run();
    ended = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int g = 0; g < NG; g++) chk("R1", "status", st_of(g), 0);
    chk("R1", "active_vld", int'(active_vld_o), 0);
    chk("R1", "done", int'(done_o), 0);
    chk("R1", "err", int'(err_o), 0);
    @(negedge clk_i);

    // R2 start on free unit, R3 stepping, R4 one-shot end
    cyc(1, 0, 0, 0, 0);
    chk("R2", "active_id", int'(active_id_o), 0);
    chk("R2", "ch", int'(ch_idx_o), 0);
    chk("R2", "st0", st_of(0), 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R3", "ch", int'(ch_idx_o), 2);
    cyc(0, 0, 0, 0, 1);
    chk("R4", "done", int'(done_o), 1);
    chk("R4", "done_id", int'(done_id_o), 0);
    chk("R4", "st0", st_of(0), 2);
    chk("R4", "active_vld", int'(active_vld_o), 0);

    // R5 continuous wrap, R12 stop
    cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    chk("R5", "done", int'(done_o), 1);
    chk("R5", "st1", st_of(1), 1);
    chk("R5", "active_vld", int'(active_vld_o), 1);
    chk("R5", "ch", int'(ch_idx_o), 0);
    cyc(0, 0, 1, 1, 0);
    chk("R12", "st1", st_of(1), 0);
    chk("R12", "active_vld", int'(active_vld_o), 0);

    // R6 burst of two passes
    cyc(1, 2, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R6", "done", int'(done_o), 1);
    chk("R6", "st2", st_of(2), 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R6", "st2", st_of(2), 3);
    chk("R6", "active_vld", int'(active_vld_o), 0);

    // R7 queue, R8 duplicate, R9 preempt and restart, R11 dispatch
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 1);
    cyc(1, 4, 0, 0, 0);
    chk("R7", "active_id", int'(active_id_o), 0);
    chk("R7", "ch", int'(ch_idx_o), 1);
    chk("R7", "st4", st_of(4), 1);
    cyc(1, 0, 0, 0, 0);
    chk("R8", "err", int'(err_o), 1);
    chk("R8", "ch", int'(ch_idx_o), 1);
    cyc(1, 7, 0, 0, 0);
    chk("R9", "active_id", int'(active_id_o), 7);
    chk("R9", "ch", int'(ch_idx_o), 0);
    chk("R9", "st0", st_of(0), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R9", "active_id restart", int'(active_id_o), 0);
    chk("R9", "ch restart", int'(ch_idx_o), 0);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R11", "active_id", int'(active_id_o), 4);
    cyc(0, 0, 0, 0, 1);
    chk("R4", "st4", st_of(4), 2);

    // R11 priority then equal-priority arrival order
    cyc(1, 3, 0, 0, 0);
    cyc(1, 2, 0, 0, 0);
    cyc(1, 6, 0, 0, 0);
    cyc(1, 7, 0, 0, 0);
    chk("R10", "active_id", int'(active_id_o), 3);
    cyc(0, 0, 1, 3, 0);
    chk("R11", "active_id", int'(active_id_o), 2);
    chk("R12", "st3", st_of(3), 0);
    cyc(0, 0, 1, 2, 0);
    chk("R11", "active_id fcfs", int'(active_id_o), 6);
    cyc(0, 0, 1, 6, 0);
    chk("R11", "active_id", int'(active_id_o), 7);
    cyc(0, 0, 0, 0, 1);

    // R10 preemption off: arrival order
    preempt_en_i = 1'b0;
    cyc(1, 4, 0, 0, 0);
    cyc(1, 7, 0, 0, 0);
    cyc(1, 5, 0, 0, 0);
    chk("R10", "active_id", int'(active_id_o), 4);
    cyc(0, 0, 0, 0, 1);
    chk("R10", "active_id", int'(active_id_o), 7);
    cyc(0, 0, 0, 0, 1);
    chk("R10", "active_id", int'(active_id_o), 5);
    cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 0, 0, 1);
    chk("R10", "active_vld", int'(active_vld_o), 0);
    preempt_en_i = 1'b1;

    // R12 stop of a group that is not running
    cyc(0, 0, 1, 1, 0);
    chk("R12", "err", int'(err_o), 1);
    chk("R12", "st1", st_of(1), 0);

    // R13 free and start on the same edge
    cyc(1, 3, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 1, 3, 0);
    chk("R13", "active_id", int'(active_id_o), 0);
    chk("R13", "st1", st_of(1), 1);
    cyc(0, 0, 1, 0, 0);
    chk("R13", "active_id", int'(active_id_o), 1);
    cyc(0, 0, 1, 1, 0);
    cyc(1, 3, 0, 0, 0);
    cyc(1, 0, 0, 0, 0);
    cyc(1, 7, 1, 3, 0);
    chk("R13", "active_id higher", int'(active_id_o), 7);
    chk("R13", "st0", st_of(0), 1);
    cyc(0, 0, 0, 0, 1);
    chk("R13", "active_id", int'(active_id_o), 0);
    cyc(0, 0, 1, 0, 0);

    // R5 pass end and preemption on the same edge
    cyc(1, 1, 0, 0, 0);
    cyc(1, 7, 0, 0, 1);
    chk("R5", "done", int'(done_o), 1);
    chk("R5", "done_id", int'(done_id_o), 1);
    chk("R9", "active_id", int'(active_id_o), 7);
    cyc(0, 0, 0, 0, 1);
    chk("R9", "active_id", int'(active_id_o), 1);
    chk("R9", "ch", int'(ch_idx_o), 0);
    cyc(0, 0, 1, 1, 0);
    chk("R12", "active_vld", int'(active_vld_o), 0);

    repeat (2) @(negedge clk_i);
    finish_run();
  end

endmodule